// File: doc/BRIEF.md
# Flash Program/Erase Batch Sequencer

This block sits on the host side of a parallel NOR flash and runs program and erase work on behalf of a simple request port. One request describes a batch. The batch is either a run of word programs at consecutive addresses or a run of block erases at consecutive block addresses. The sequencer produces every command write and every status read on the flash bus itself. It waits for the device to report ready after each operation and returns one coded result when the whole batch has finished.

The device keeps its error flags until they are explicitly cleared, so the sequencer does not inspect errors after each operation. It clears the flags once before the batch and decodes the accumulated flags once at the end. A poll limit guards every operation, so a device that never reports ready still ends the batch. Every batch, including one that timed out, ends with a command that returns the device to array-read mode.

Top module: `flash_batch_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle and drops in the cycle after a request is accepted. `done` is a single-cycle pulse that marks the end of a batch, and `err_code` is valid while `done` is high.
- R2: The first bus write of every batch is the status-clear command 0x50 at the request address. Flags left behind by an earlier batch therefore never reach the next result.
- R3: For a program batch, word i (i = 0 .. count-1) takes two writes to address `req_addr + i`: first the setup command 0x40, then the data value `req_data + i`.
- R4: For an erase batch, block i takes the erase setup command 0x20 followed by the confirm command 0xD0. Both writes carry the address `req_addr + i * 2^BLK_SHIFT`.
- R5: After each program or erase, the status is polled with read cycles. In each read cycle chip enable and output enable are low together, and chip enable returns high between reads. No further command write is issued until a read returns bit 7 = 1.
- R6: The result is decoded once, from the last ready status of the batch. The status bits are bit 5 erase fail, bit 4 program fail and bit 3 supply fault. The codes are: 0 no error; 1 bit 4 alone; 2 bit 5 without bit 3; 3 bit 3 without bit 5; 4 bits 3 and 5 (erase skipped for supply). The flags accumulate, so a failure on any operation of the batch still shows at the end.
- R7: If MAX_POLLS consecutive reads after one operation all show bit 7 = 0, the batch stops. The remaining items are skipped and the result code is 7.
- R8: The last bus write of every batch is the read-array command 0xFF, including batches that timed out.
- R9: Write enable stays low for at least WR_PULSE cycles (WR_PULSE of 2 or more) and is high for at least one cycle between two writes. The data bus is driven whenever write enable is low, and write enable and output enable are never low together.
- R10: A request with count 0 produces only the clear and read-array writes and returns code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Batch request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 1 | 0 program batch, 1 erase batch |
| req_addr | input | ADDR_W | First word address or first block address |
| req_data | input | DATA_W | Data of the first programmed word |
| req_count | input | CNT_W | Number of words or blocks |
| done | output | 1 | One-cycle end-of-batch pulse |
| err_code | output | 3 | Batch result code |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq_out | output | DATA_W | Data driven toward the flash |
| flash_dq_oe | output | 1 | Data bus drive enable |
| flash_dq_in | input | DATA_W | Data returned by the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds the block with a 12-bit address, a 16-bit data bus and a 4-bit count. BLK_SHIFT is 4, so consecutive erase addresses are easy to recognise. WR_PULSE is 2, the shortest legal strobe, so any shortened pulse shows up directly. MAX_POLLS is 8, so a device model that never reports ready reaches the timeout within a few dozen cycles. These values keep every batch short enough to cover all result codes, a zero-length batch, and a clean batch that follows a failed one.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   // command bytes understood by the flash
   localparam logic [7:0] CMD_CLEAR_STATUS  = 8'h50;
   localparam logic [7:0] CMD_PROG_SETUP    = 8'h40;
   localparam logic [7:0] CMD_ERASE_SETUP   = 8'h20;
   localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;
   localparam logic [7:0] CMD_READ_ARRAY    = 8'hFF;

   // status bit positions
   localparam int SR_READY      = 7;
   localparam int SR_ERASE_FAIL = 5;
   localparam int SR_PROG_FAIL  = 4;
   localparam int SR_SUPPLY     = 3;

   typedef enum logic [2:0] {
      ERR_NONE          = 3'd0,
      ERR_PROG          = 3'd1,
      ERR_ERASE         = 3'd2,
      ERR_SUPPLY        = 3'd3,
      ERR_ERASE_SKIPPED = 3'd4,
      ERR_TIMEOUT       = 3'd7
   } err_code_t;

   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } batch_op_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_SETUP,
      ST_CONFIRM,
      ST_POLL,
      ST_READARR
   } seq_state_t;

   typedef enum logic [1:0] {
      BUS_IDLE,
      BUS_STROBE,
      BUS_GAP
   } bus_state_t;

   // sticky flags kept by the sequencer
   typedef struct packed {
      logic erase_fail;
      logic prog_fail;
      logic supply;
   } sticky_t;

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 16,
   parameter int WR_PULSE = 3,
   parameter int RD_PULSE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_write,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] flash_addr,
   output logic [DATA_W-1:0] flash_dq_out,
   output logic              flash_dq_oe,
   input  logic [DATA_W-1:0] flash_dq_in,
   output logic              flash_ce_n,
   output logic              flash_we_n,
   output logic              flash_oe_n
);

   localparam int LONGEST = (WR_PULSE > RD_PULSE) ? WR_PULSE : RD_PULSE;
   localparam int PW      = $clog2(LONGEST + 1);
   localparam logic [PW-1:0] WR_LAST = PW'(WR_PULSE - 1);
   localparam logic [PW-1:0] RD_LAST = PW'(RD_PULSE - 1);

   bus_state_t    state;
   logic [PW-1:0] remain;
   logic          cur_write;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= BUS_IDLE;
         remain       <= '0;
         cur_write    <= 1'b0;
         done         <= 1'b0;
         rdata        <= '0;
         flash_addr   <= '0;
         flash_dq_out <= '0;
         flash_dq_oe  <= 1'b0;
         flash_ce_n   <= 1'b1;
         flash_we_n   <= 1'b1;
         flash_oe_n   <= 1'b1;
      end else begin
         done <= 1'b0;
         unique case (state)
            BUS_IDLE: begin
               if (start) begin
                  cur_write   <= is_write;
                  flash_addr  <= addr_in;
                  flash_ce_n  <= 1'b0;
                  flash_we_n  <= !is_write;
                  flash_oe_n  <= is_write;
                  flash_dq_oe <= is_write;
                  if (is_write) begin
                     flash_dq_out <= wdata_in;
                     remain       <= WR_LAST;
                  end else begin
                     remain       <= RD_LAST;
                  end
                  state <= BUS_STROBE;
               end
            end
            BUS_STROBE: begin
               if (remain == '0) begin
                  // address and data stay put through the recovery cycle
                  flash_ce_n  <= 1'b1;
                  flash_we_n  <= 1'b1;
                  flash_oe_n  <= 1'b1;
                  flash_dq_oe <= 1'b0;
                  if (!cur_write) begin
                     rdata <= flash_dq_in;
                  end
                  state <= BUS_GAP;
               end else begin
                  remain <= remain - 1'b1;
               end
            end
            BUS_GAP: begin
               done  <= 1'b1;
               state <= BUS_IDLE;
            end
            default: state <= BUS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
   parameter int MAX_POLLS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic expired
);

   localparam int TW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
   localparam logic [TW-1:0] LAST = TW'(MAX_POLLS - 1);

   logic [TW-1:0] polls;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         polls <= '0;
      end else if (clear) begin
         polls <= '0;
      end else if (tick && polls != LAST) begin
         polls <= polls + 1'b1;
      end
   end

   // high while the read in flight is the last one allowed
   assign expired = (polls == LAST);

endmodule

// File: rtl/flash_err_decode.sv
module flash_err_decode
   import flash_seq_pkg::*;
(
   input  sticky_t   flags,
   input  logic      timed_out,
   output err_code_t code
);

   always_comb begin
      if (timed_out) begin
         code = ERR_TIMEOUT;
      end else if (flags.supply && flags.erase_fail) begin
         code = ERR_ERASE_SKIPPED;
      end else if (flags.supply) begin
         code = ERR_SUPPLY;
      end else if (flags.erase_fail) begin
         code = ERR_ERASE;
      end else if (flags.prog_fail) begin
         code = ERR_PROG;
      end else begin
         code = ERR_NONE;
      end
   end

endmodule

// File: rtl/flash_batch_seq.sv
module flash_batch_seq
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 8,
   parameter int BLK_SHIFT = 15,
   parameter int WR_PULSE  = 3,
   parameter int RD_PULSE  = 2,
   parameter int MAX_POLLS = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [CNT_W-1:0]  req_count,
   output logic              done,
   output logic [2:0]        err_code,
   output logic [ADDR_W-1:0] flash_addr,
   output logic [DATA_W-1:0] flash_dq_out,
   output logic              flash_dq_oe,
   input  logic [DATA_W-1:0] flash_dq_in,
   output logic              flash_ce_n,
   output logic              flash_we_n,
   output logic              flash_oe_n
);

   // elaboration-time parameter checks
   if (WR_PULSE < 2) begin : g_bad_wr_pulse
      $error("flash_batch_seq: WR_PULSE must be at least 2");
   end
   if (RD_PULSE < 1) begin : g_bad_rd_pulse
      $error("flash_batch_seq: RD_PULSE must be at least 1");
   end
   if (DATA_W < 8) begin : g_bad_data_w
      $error("flash_batch_seq: DATA_W must be at least 8");
   end
   if (MAX_POLLS < 1) begin : g_bad_polls
      $error("flash_batch_seq: MAX_POLLS must be at least 1");
   end
   if (BLK_SHIFT >= ADDR_W) begin : g_bad_blk
      $error("flash_batch_seq: BLK_SHIFT must be below ADDR_W");
   end

   localparam int CMD_PAD = DATA_W - 8;

   seq_state_t        state;
   batch_op_t         op_q;
   logic [ADDR_W-1:0] base_addr;
   logic [DATA_W-1:0] base_data;
   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  idx;
   sticky_t           flags_q;
   logic              timeout_q;
   logic              issued;
   logic [2:0]        err_q;
   logic              done_q;

   logic              bus_start;
   logic              bus_write;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic              bus_done;
   logic [DATA_W-1:0] bus_rdata;

   logic              tmr_clear;
   logic              tmr_tick;
   logic              tmr_expired;
   err_code_t         dec_code;

   logic [ADDR_W-1:0] item_addr;
   logic [DATA_W-1:0] item_data;
   logic              last_item;
   logic              rd_ready;
   sticky_t           rd_flags;

   // command words widened to the data bus
   function automatic logic [DATA_W-1:0] widen(input logic [7:0] cmd);
      return DATA_W'(cmd);
   endfunction

   // status fields of the captured read; unused bits folded away
   if (DATA_W > 8) begin : g_wide_bus
      logic unused_rd_bits;
      assign unused_rd_bits = ^{bus_rdata[DATA_W-1:8], bus_rdata[6], bus_rdata[2:0]};
   end else begin : g_byte_bus
      logic unused_rd_bits;
      assign unused_rd_bits = ^{bus_rdata[6], bus_rdata[2:0]};
   end

   assign rd_ready            = bus_rdata[SR_READY];
   assign rd_flags.erase_fail = bus_rdata[SR_ERASE_FAIL];
   assign rd_flags.prog_fail  = bus_rdata[SR_PROG_FAIL];
   assign rd_flags.supply     = bus_rdata[SR_SUPPLY];

   // address and data of the current item
   always_comb begin
      if (op_q == OP_ERASE) begin
         item_addr = base_addr + (ADDR_W'(idx) << BLK_SHIFT);
      end else begin
         item_addr = base_addr + ADDR_W'(idx);
      end
      item_data = base_data + DATA_W'(idx);
   end

   assign last_item = (idx == count_q - CNT_W'(1));

   // what the bus engine is asked to do in each state
   always_comb begin
      bus_write = 1'b1;
      bus_addr  = item_addr;
      bus_wdata = widen(CMD_CLEAR_STATUS);
      unique case (state)
         ST_CLEAR: begin
            bus_addr  = base_addr;
            bus_wdata = widen(CMD_CLEAR_STATUS);
         end
         ST_SETUP: begin
            bus_wdata = (op_q == OP_ERASE) ? widen(CMD_ERASE_SETUP) : widen(CMD_PROG_SETUP);
         end
         ST_CONFIRM: begin
            bus_wdata = (op_q == OP_ERASE) ? widen(CMD_ERASE_CONFIRM) : item_data;
         end
         ST_POLL: begin
            bus_write = 1'b0;
         end
         ST_READARR: begin
            bus_addr  = base_addr;
            bus_wdata = widen(CMD_READ_ARRAY);
         end
         default: ;
      endcase
   end

   assign bus_start = (state != ST_IDLE) && !issued;
   assign tmr_clear = (state == ST_CONFIRM) && bus_done;
   assign tmr_tick  = (state == ST_POLL) && bus_done && !rd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op_q      <= OP_PROGRAM;
         base_addr <= '0;
         base_data <= '0;
         count_q   <= '0;
         idx       <= '0;
         flags_q   <= '0;
         timeout_q <= 1'b0;
         issued    <= 1'b0;
         err_q     <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (bus_start) begin
            issued <= 1'b1;
         end else if (bus_done) begin
            issued <= 1'b0;
         end
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  op_q      <= batch_op_t'(req_op);
                  base_addr <= req_addr;
                  base_data <= req_data;
                  count_q   <= req_count;
                  idx       <= '0;
                  flags_q   <= '0;
                  timeout_q <= 1'b0;
                  state     <= ST_CLEAR;
               end
            end
            ST_CLEAR: begin
               if (bus_done) begin
                  state <= (count_q == '0) ? ST_READARR : ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (bus_done) begin
                  state <= ST_CONFIRM;
               end
            end
            ST_CONFIRM: begin
               if (bus_done) begin
                  state <= ST_POLL;
               end
            end
            ST_POLL: begin
               if (bus_done) begin
                  if (rd_ready) begin
                     flags_q <= rd_flags;
                     if (last_item) begin
                        state <= ST_READARR;
                     end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_SETUP;
                     end
                  end else if (tmr_expired) begin
                     timeout_q <= 1'b1;
                     state     <= ST_READARR;
                  end
               end
            end
            ST_READARR: begin
               if (bus_done) begin
                  err_q  <= dec_code;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign done      = done_q;
   assign err_code  = err_q;

   flash_bus_cycle #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .WR_PULSE (WR_PULSE),
      .RD_PULSE (RD_PULSE)
   ) u_bus (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (bus_start),
      .is_write     (bus_write),
      .addr_in      (bus_addr),
      .wdata_in     (bus_wdata),
      .done         (bus_done),
      .rdata        (bus_rdata),
      .flash_addr   (flash_addr),
      .flash_dq_out (flash_dq_out),
      .flash_dq_oe  (flash_dq_oe),
      .flash_dq_in  (flash_dq_in),
      .flash_ce_n   (flash_ce_n),
      .flash_we_n   (flash_we_n),
      .flash_oe_n   (flash_oe_n)
   );

   flash_poll_timer #(
      .MAX_POLLS (MAX_POLLS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (tmr_clear),
      .tick    (tmr_tick),
      .expired (tmr_expired)
   );

   flash_err_decode u_decode (
      .flags     (flags_q),
      .timed_out (timeout_q),
      .code      (dec_code)
   );

   if (CMD_PAD < 0) begin : g_never
      $error("flash_batch_seq: negative command pad");
   end

endmodule

// File: rtl/flash_batch_seq_chk.sv
module flash_batch_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic done,
   input logic flash_ce_n,
   input logic flash_we_n,
   input logic flash_oe_n,
   input logic flash_dq_oe
);

   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!flash_we_n && !flash_oe_n));

   assert_we_min_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flash_we_n) |=> !flash_we_n);

   assert_we_recovery_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_we_n) |=> flash_we_n);

   assert_dq_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_we_n |-> flash_dq_oe);

   assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_bus_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (flash_ce_n && flash_we_n && flash_oe_n));

   assert_read_selects_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_oe_n |-> !flash_ce_n);

   assert_read_toggles_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_oe_n) |-> flash_ce_n);

endmodule

bind flash_batch_seq flash_batch_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .done        (done),
   .flash_ce_n  (flash_ce_n),
   .flash_we_n  (flash_we_n),
   .flash_oe_n  (flash_oe_n),
   .flash_dq_oe (flash_dq_oe)
);

// File: tb/tb_flash_batch_seq.sv
module tb_flash_batch_seq;

   localparam int AW    = 12;
   localparam int DW    = 16;
   localparam int CW    = 4;
   localparam int BSH   = 4;
   localparam int WRP   = 2;
   localparam int RDP   = 2;
   localparam int MAXP  = 8;
   localparam int PBUSY = 5;
   localparam int EBUSY = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_op = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic [CW-1:0] req_count = '0;
   logic          done;
   logic [2:0]    err_code;
   logic [AW-1:0] f_addr;
   logic [DW-1:0] f_dq_out;
   logic          f_dq_oe;
   logic [DW-1:0] f_dq_in;
   logic          f_ce_n, f_we_n, f_oe_n;

   always #4 clk = ~clk;

   flash_batch_seq #(
      .ADDR_W (AW), .DATA_W (DW), .CNT_W (CW), .BLK_SHIFT (BSH),
      .WR_PULSE (WRP), .RD_PULSE (RDP), .MAX_POLLS (MAXP)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_op (req_op),
      .req_addr (req_addr), .req_data (req_data), .req_count (req_count),
      .done (done), .err_code (err_code),
      .flash_addr (f_addr), .flash_dq_out (f_dq_out), .flash_dq_oe (f_dq_oe),
      .flash_dq_in (f_dq_in), .flash_ce_n (f_ce_n), .flash_we_n (f_we_n),
      .flash_oe_n (f_oe_n)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- flash device model ----------------
   logic          cur_op = 1'b0;
   logic [AW-1:0] cur_base = '0;
   logic [DW-1:0] cur_data = '0;
   logic          m_vpp = 1'b0, m_pfail = 1'b0, m_efail = 1'b0, m_hang = 1'b0;
   int            idx_m = 0;
   int            writes_n = 0, prog_n = 0, erase_n = 0, reads_n = 0;
   int            seq_err = 0, busy_viol = 0, strobe_viol = 0;
   int            first_cmd = 0, last_cmd = 0;
   int            busy = 0;
   int            we_low = 0, we_high = 1;
   logic          we_prev = 1'b1, oe_prev = 1'b1;
   logic          pend_prog = 1'b0, pend_erase = 1'b0, mode_status = 1'b0;
   logic          st_supply = 1'b0, st_prog = 1'b0, st_erase = 1'b0;
   logic          rdy;

   assign rdy     = (busy == 0) && !m_hang;
   assign f_dq_in = mode_status ? {8'h00, rdy, 1'b0, st_erase, st_prog, st_supply, 3'b000}
                                : 16'hA5A5;

   task automatic on_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [AW-1:0] eaddr;
      eaddr = cur_base + (AW'(idx_m) << BSH);
      if (busy > 0) busy_viol++;
      if (writes_n == 0) begin
         first_cmd = int'(d);
         if (a != cur_base) seq_err++;
      end
      writes_n++;
      last_cmd = int'(d);
      if (pend_prog) begin
         pend_prog = 1'b0;
         if (a != cur_base + AW'(idx_m) || d != cur_data + DW'(idx_m)) seq_err++;
         if (m_vpp) begin st_supply = 1'b1; st_prog = 1'b1; end
         else if (m_pfail && idx_m == 0) st_prog = 1'b1;
         busy = PBUSY; mode_status = 1'b1; idx_m++; prog_n++;
      end else if (pend_erase) begin
         pend_erase = 1'b0;
         if (d != 16'h00D0 || a != eaddr) seq_err++;
         if (m_vpp) begin st_supply = 1'b1; st_erase = 1'b1; busy = 2; end
         else begin
            if (m_efail && idx_m == 0) st_erase = 1'b1;
            busy = EBUSY;
         end
         mode_status = 1'b1; idx_m++; erase_n++;
      end else begin
         case (d)
            16'h0050: begin st_supply = 1'b0; st_prog = 1'b0; st_erase = 1'b0; mode_status = 1'b1; end
            16'h00FF: mode_status = 1'b0;
            16'h0040: begin if (cur_op || a != cur_base + AW'(idx_m)) seq_err++; pend_prog = 1'b1; end
            16'h0020: begin if (!cur_op || a != eaddr) seq_err++; pend_erase = 1'b1; end
            default: seq_err++;
         endcase
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         we_prev = 1'b1; oe_prev = 1'b1; we_low = 0; we_high = 1; busy = 0;
         pend_prog = 1'b0; pend_erase = 1'b0; mode_status = 1'b0;
      end else begin
         if (busy > 0) busy--;
         if (!f_we_n && !f_oe_n) strobe_viol++;
         if (!f_we_n) begin
            if (we_prev && we_high < 1) strobe_viol++;
            if (f_dq_oe !== 1'b1) strobe_viol++;
            we_low++;
         end else if (!we_prev) begin
            if (we_low < WRP) strobe_viol++;
            we_low = 0; we_high = 1;
            on_write(f_addr, f_dq_out);
         end else begin
            we_high++;
         end
         if (!f_oe_n && oe_prev) reads_n++;
         we_prev = f_we_n; oe_prev = f_oe_n;
      end
   end

   // ---------------- stimulus table ----------------
   typedef struct packed {
      logic          op;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic [CW-1:0] cnt;
      logic          vpp;
      logic          pfail;
      logic          efail;
      logic          hang;
      logic [2:0]    exp_err;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 12'h010, 16'h1234, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},  // R3 clean program
      '{1'b1, 12'h100, 16'h0000, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},  // R4 clean erase
      '{1'b0, 12'h020, 16'h00F0, 4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1},  // R6 sticky program fail
      '{1'b1, 12'h200, 16'h0000, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2},  // R6 sticky erase fail
      '{1'b0, 12'h030, 16'h5555, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3},  // R6 supply on program
      '{1'b0, 12'h040, 16'h0AAA, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},  // R2 flags cleared
      '{1'b1, 12'h300, 16'h0000, 4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4},  // R6 erase skipped
      '{1'b0, 12'h050, 16'h1111, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},  // R10 empty batch
      '{1'b1, 12'h400, 16'h0000, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7},  // R7 timeout
      '{1'b1, 12'h500, 16'h0000, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}   // R2 clean after timeout
   };

   task automatic run_vec(input vec_t v);
      int cyc;
      int items;
      cur_op = v.op; cur_base = v.addr; cur_data = v.data;
      m_vpp = v.vpp; m_pfail = v.pfail; m_efail = v.efail; m_hang = v.hang;
      idx_m = 0; writes_n = 0; prog_n = 0; erase_n = 0; reads_n = 0;
      seq_err = 0; busy_viol = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_data = v.data; req_count = v.cnt;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 ready low while busy", int'(req_ready), 0);
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      chk("R1 done seen", int'(done), 1);
      chk("R6/R7 result code", int'(err_code), int'(v.exp_err));
      @(negedge clk);
      chk("R1 done single cycle", int'(done), 0);
      chk("R1 ready after done", int'(req_ready), 1);
      items = v.hang ? 1 : int'(v.cnt);
      chk("R3/R4/R10 bus write count", writes_n, v.hang ? 4 : 2 + 2 * int'(v.cnt));
      chk("R3/R4 items issued", v.op ? erase_n : prog_n, items);
      chk("R2 first write clear", first_cmd, 16'h0050);
      chk("R8 last write read array", last_cmd, 16'h00FF);
      chk("R3/R4 command order and addresses", seq_err, 0);
      chk("R5 no write while busy", busy_viol, 0);
      if (v.hang) chk("R7 polls before timeout", reads_n, MAXP);
      else        chk("R5 at least one poll per item", int'(reads_n >= items), 1);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R1, R9)
      chk("R1 ready after reset", int'(req_ready), 1);
      chk("R1 done low after reset", int'(done), 0);
      chk("R9 we high after reset", int'(f_we_n), 1);
      chk("R9 oe high after reset", int'(f_oe_n), 1);
      chk("R5 ce high after reset", int'(f_ce_n), 1);

      for (int i = 0; i < NV; i++) begin
         run_vec(VECS[i]);
      end

      // idle request line low: nothing happens on the bus (R1)
      writes_n = 0;
      repeat (20) @(negedge clk);
      chk("R1 no bus activity while idle", writes_n, 0);
      chk("R9 strobe timing", strobe_viol, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule